// File: doc/BRIEF.md
# Relocatable Interrupt Vector Address Generator

This block picks one interrupt from a set of pending requests and produces the program-memory word address of its vector. Vector slots are two words wide. Slot 0 belongs to reset. Slots 1 to 20 belong to the interrupt sources, from external interrupt 0 up to the store-to-program-memory-ready source. A select bit moves the interrupt table between the bottom of flash and the start of the boot section. A separate reset-placement input moves only the reset vector, and does not depend on the table select.

Two lock inputs can block interrupts. The choice depends on where the table sits and which flash section the program counter is in. A global enable and an external protection mask also block acceptance. An accepted vector is presented on a valid/ready output. While `vec_valid` is high and `vec_ready` is low, the presented index and address hold unchanged, and no new request is taken. A request is sampled only when the output register is empty or is being emptied in the same cycle. Requests are levels that the sources keep asserted until they are serviced.

Top module: `irq_vector_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `vec_valid` is low.
- R2: The vector for index n (1..20) is at base + 2*n. Index 1 gives base+0x02 and index 20 gives base+0x28. `vec_idx` carries n.
- R3: With `vec_sel`=0 the table base is 0. With `vec_sel`=1 the base is the boot section start, which is 0x1C00 for the default 8K-word flash with a 1K-word boot section.
- R4: `reset_addr` is 0 when `rst_boot`=0 and 0x1C00 when `rst_boot`=1, whatever `vec_sel` is. It is combinational.
- R5: With `vec_sel`=1 and `app_lock`=1, no interrupt is accepted while `pc` is below the boot start. `app_lock` has no effect when `vec_sel`=0.
- R6: With `vec_sel`=0 and `boot_lock`=1, no interrupt is accepted while `pc` is at or above the boot start. `boot_lock` has no effect when `vec_sel`=1.
- R7: When several requests are pending, the lowest index is accepted. `irq_req` bit k is the request for index k+1.
- R8: No interrupt is accepted while `global_en`=0 or `prot_mask`=1.
- R9: A request sampled at a clock edge appears on `vec_valid` right after that edge. While `vec_valid`=1 and `vec_ready`=0, `vec_idx` and `vec_addr` hold, even if a higher-priority request arrives.
- R10: `pc`=0x1BFF counts as the application section and `pc`=0x1C00 counts as the boot section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | NUM_SRC | Pending requests; bit k is index k+1 |
| global_en | input | 1 | Global interrupt enable |
| prot_mask | input | 1 | Blocks acceptance when high (change-protection window) |
| vec_sel | input | 1 | 0: table at flash start, 1: table at boot start |
| rst_boot | input | 1 | 1: reset vector at boot start |
| app_lock | input | 1 | Blocks interrupts while running in the application section with the table in boot |
| boot_lock | input | 1 | Blocks interrupts while running in the boot section with the table in the application section |
| pc | input | AW | Current program counter (word address) |
| vec_valid | output | 1 | Accepted vector is presented |
| vec_ready | input | 1 | Consumer takes the vector |
| vec_idx | output | IW | Index of the accepted source |
| vec_addr | output | AW | Vector word address |
| reset_addr | output | AW | Reset vector word address |

## Verification
`reset_addr` is combinational, so the bench checks it a few nanoseconds after it changes the inputs. Inputs change 2 ns after a rising edge, and the next edge samples them. An accepted vector is therefore present at the falling edge right after that sampling edge. The scoreboard monitor compares it there, on the cycle of the `vec_valid`/`vec_ready` handshake. For blocked cases, the bench checks at the same falling edge that `vec_valid` stays low. During back-pressure, it checks that index and address hold for several cycles before it raises `vec_ready`.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  // control bits that select table placement and lock behaviour
  typedef struct packed {
    logic vec_sel;
    logic app_lock;
    logic boot_lock;
  } lock_cfg_t;
endpackage

// File: rtl/irqv_boot_region.sv
module irqv_boot_region #(
  parameter int FLASH_WORDS = 8192,
  parameter int BOOT_WORDS  = 1024,
  parameter int AW          = 13
) (
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] boot_base,
  output logic          in_boot
);
  localparam int BootStart = FLASH_WORDS - BOOT_WORDS;

  assign boot_base = AW'(BootStart);
  assign in_boot   = (pc >= boot_base);
endmodule

// File: rtl/irqv_gate.sv
module irqv_gate
  import irqv_pkg::*;
(
  input  logic      global_en,
  input  logic      prot_mask,
  input  lock_cfg_t cfg,
  input  logic      in_boot,
  output logic      allow
);
  logic app_block;
  logic boot_block;

  // table in boot, running in application code
  assign app_block  = cfg.vec_sel  & cfg.app_lock  & ~in_boot;
  // table in application area, running in boot code
  assign boot_block = ~cfg.vec_sel & cfg.boot_lock &  in_boot;

  assign allow = global_en & ~prot_mask & ~app_block & ~boot_block;
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int N  = 20,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N:0]   lower_any;
  logic [N-1:0] grant;

  assign lower_any[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign grant[k]       = req[k] & ~lower_any[k];
    assign lower_any[k+1] = lower_any[k] | req[k];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) idx = idx | IW'(k + 1);
    end
  end

  assign hit = lower_any[N];
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irqv_pkg::*;
#(
  parameter int NUM_SRC     = 20,
  parameter int FLASH_WORDS = 8192,
  parameter int BOOT_WORDS  = 1024,
  localparam int IW = $clog2(NUM_SRC + 1),
  localparam int AW = $clog2(FLASH_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               global_en,
  input  logic               prot_mask,
  input  logic               vec_sel,
  input  logic               rst_boot,
  input  logic               app_lock,
  input  logic               boot_lock,
  input  logic [AW-1:0]      pc,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [IW-1:0]      vec_idx,
  output logic [AW-1:0]      vec_addr,
  output logic [AW-1:0]      reset_addr
);
  logic [AW-1:0] boot_base;
  logic          in_boot;
  logic          allow;
  logic          hit;
  logic [IW-1:0] pick_idx;
  logic [AW-1:0] table_base;
  logic          slot_free;
  logic          load;
  lock_cfg_t     cfg;

  assign cfg = '{vec_sel: vec_sel, app_lock: app_lock, boot_lock: boot_lock};

  irqv_boot_region #(
    .FLASH_WORDS(FLASH_WORDS),
    .BOOT_WORDS (BOOT_WORDS),
    .AW         (AW)
  ) i_region (
    .pc       (pc),
    .boot_base(boot_base),
    .in_boot  (in_boot)
  );

  irqv_gate i_gate (
    .global_en(global_en),
    .prot_mask(prot_mask),
    .cfg      (cfg),
    .in_boot  (in_boot),
    .allow    (allow)
  );

  irqv_prio #(
    .N (NUM_SRC),
    .IW(IW)
  ) i_prio (
    .req(irq_req),
    .hit(hit),
    .idx(pick_idx)
  );

  assign table_base = vec_sel  ? boot_base : '0;
  assign reset_addr = rst_boot ? boot_base : '0;

  assign slot_free = ~vec_valid | vec_ready;
  assign load      = slot_free & allow & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_idx   <= '0;
      vec_addr  <= '0;
    end else if (slot_free) begin
      vec_valid <= load;
      if (load) begin
        vec_idx  <= pick_idx;
        vec_addr <= table_base + AW'({pick_idx, 1'b0});
      end
    end
  end

  // R9: presented vector holds under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_idx) && $stable(vec_addr)));

  // R2: a presented index is a real interrupt source
  a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_idx != '0 && int'(vec_idx) <= NUM_SRC));

  // R7: no lower index was pending when the presented one was taken
  a_r7_lowest: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && $past(load)) |->
      (($past(irq_req) & ((NUM_SRC'(1) << (vec_idx - IW'(1))) - NUM_SRC'(1))) == '0));

  // R8: disabled or protected means nothing new is presented
  a_r8_disabled: assert property (@(posedge clk) disable iff (rst)
    ((!global_en || prot_mask) && slot_free) |=> !vec_valid);

  // R5: application lock with table in boot section
  a_r5_app_lock: assert property (@(posedge clk) disable iff (rst)
    (vec_sel && app_lock && (pc < boot_base) && slot_free) |=> !vec_valid);

  // R6: boot lock with table in application section
  a_r6_boot_lock: assert property (@(posedge clk) disable iff (rst)
    (!vec_sel && boot_lock && (pc >= boot_base) && slot_free) |=> !vec_valid);
endmodule

// File: tb/test_irq_vector_gen.sv
module test_irq_vector_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] irq_req = '0;
  logic        global_en = 1'b1;
  logic        prot_mask = 1'b0;
  logic        vec_sel = 1'b0;
  logic        rst_boot = 1'b0;
  logic        app_lock = 1'b0;
  logic        boot_lock = 1'b0;
  logic [12:0] pc = '0;
  logic        vec_valid;
  logic        vec_ready = 1'b1;
  logic [4:0]  vec_idx;
  logic [12:0] vec_addr;
  logic [12:0] reset_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int    q_idx[$];
  int    q_addr[$];
  string q_tag[$];

  always #5 clk = ~clk;

  irq_vector_gen i_irq_vector_gen (
    .clk(clk), .rst(rst), .irq_req(irq_req), .global_en(global_en),
    .prot_mask(prot_mask), .vec_sel(vec_sel), .rst_boot(rst_boot),
    .app_lock(app_lock), .boot_lock(boot_lock), .pc(pc),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_idx(vec_idx),
    .vec_addr(vec_addr), .reset_addr(reset_addr)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected vector address, computed from R2/R3
  function automatic int exp_addr(int idx);
    return (vec_sel ? 32'h1C00 : 0) + 2 * idx;
  endfunction

  task automatic push(int idx, string tag);
    q_idx.push_back(idx);
    q_addr.push_back(exp_addr(idx));
    q_tag.push_back(tag);
  endtask

  // monitor: compares every handshake against the scoreboard
  always @(negedge clk) begin
    if (!rst && vec_valid && vec_ready) begin
      if (q_idx.size() == 0) begin
        chk(1'b0, "unexpected vector", int'(vec_idx), 0);
      end else begin
        int ei;
        int ea;
        string t;
        ei = q_idx.pop_front();
        ea = q_addr.pop_front();
        t  = q_tag.pop_front();
        chk(int'(vec_idx) == ei, {t, " idx"}, int'(vec_idx), ei);
        chk(int'(vec_addr) == ea, {t, " addr"}, int'(vec_addr), ea);
      end
    end
  end

  // one request pulse that must be accepted
  task automatic take(logic [19:0] req, int idx, string tag);
    irq_req = req;
    push(idx, tag);
    @(posedge clk); #2;
    irq_req = '0;
    @(posedge clk); #2;
  endtask

  // one request pulse that must be blocked
  task automatic blocked(logic [19:0] req, string tag);
    irq_req = req;
    @(posedge clk); #2;
    @(negedge clk);
    chk(vec_valid == 1'b0, tag, int'(vec_valid), 0);
    irq_req = '0;
    @(posedge clk); #2;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(vec_valid == 1'b0, "R1 valid in reset", int'(vec_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(vec_valid == 1'b0, "R1 valid after reset", int'(vec_valid), 0);
    @(posedge clk); #2;

    // R4 reset vector placement
    rst_boot = 1'b0; vec_sel = 1'b1; #1;
    chk(reset_addr == 13'h0000, "R4 reset at 0", int'(reset_addr), 0);
    rst_boot = 1'b1; vec_sel = 1'b0; #1;
    chk(reset_addr == 13'h1C00, "R4 reset at boot", int'(reset_addr), 32'h1C00);
    rst_boot = 1'b0; #1;
    @(posedge clk); #2;

    // R2/R3 table at flash start, then at boot start
    vec_sel = 1'b0; pc = 13'h0100;
    take(20'h00001, 1, "R2 R3 sel0 idx1");
    take(20'h80000, 20, "R2 R3 sel0 idx20");
    vec_sel = 1'b1; pc = 13'h1C40;
    take(20'h00001, 1, "R2 R3 sel1 idx1");
    take(20'h80000, 20, "R2 R3 sel1 idx20");

    // R7 priority
    take(20'h04044, 3, "R7 lowest wins");
    vec_sel = 1'b0; pc = 13'h0100;
    take(20'hA0010, 5, "R7 lowest wins sel0");

    // R8 enable and protection mask
    global_en = 1'b0;
    blocked(20'h00008, "R8 global enable low");
    global_en = 1'b1; prot_mask = 1'b1;
    blocked(20'h00008, "R8 protection mask");
    prot_mask = 1'b0;

    // R5 application lock, R10 boundary
    vec_sel = 1'b1; app_lock = 1'b1; pc = 13'h1BFF;
    blocked(20'h00002, "R5 R10 app lock at 0x1BFF");
    pc = 13'h1C00;
    take(20'h00002, 2, "R5 R10 app lock at 0x1C00");
    vec_sel = 1'b0; pc = 13'h0000;
    take(20'h00002, 2, "R5 app lock ignored sel0");
    app_lock = 1'b0;

    // R6 boot lock, R10 boundary
    boot_lock = 1'b1; pc = 13'h1C00;
    blocked(20'h00100, "R6 R10 boot lock at 0x1C00");
    pc = 13'h1BFF;
    take(20'h00100, 9, "R6 R10 boot lock at 0x1BFF");
    vec_sel = 1'b1; pc = 13'h1FFF;
    take(20'h00100, 9, "R6 boot lock ignored sel1");
    boot_lock = 1'b0;

    // R9 back-pressure
    vec_sel = 1'b0; pc = 13'h0040; vec_ready = 1'b0;
    irq_req = 20'h00010;
    @(posedge clk); #2;
    irq_req = 20'h00001;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(vec_valid == 1'b1, "R9 valid held", int'(vec_valid), 1);
      chk(vec_idx == 5'd5, "R9 idx held", int'(vec_idx), 5);
      chk(vec_addr == 13'h000A, "R9 addr held", int'(vec_addr), 32'h000A);
    end
    @(posedge clk); #2;
    push(5, "R9 held vector");
    push(1, "R9 next vector");
    vec_ready = 1'b1;
    @(posedge clk); #2;
    irq_req = '0;
    repeat (3) @(posedge clk);
    #2;
    chk(vec_valid == 1'b0, "R9 idle after drain", int'(vec_valid), 0);
    chk(q_idx.size() == 0, "R9 scoreboard drained", q_idx.size(), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule